// File: doc/BRIEF.md
# Activity-Driven Thread Placement Arbiter

This block sits in the centre of a multicore die whose cores each run several hardware threads. Every core reports an activity figure, and the arbiter keeps a count of each core's free thread slots. When a thread has to be placed, or a checker thread that is falling behind asks to be moved, the arbiter looks for a core with a free slot. It takes the one with the lowest activity and returns its index one cycle later. The granted core's free count drops by one, and a per-core release strobe gives a slot back.

Two activity sources come in side by side: plain instructions per cycle and a weighted variant. A select input chooses which one the search compares. A free-running timer raises a one-cycle pulse at a fixed period so that the rest of the system can rebalance thread placement.

The arbiter also splits a fixed block of fetch cycles among the threads of one core. Each valid thread gets a share in proportion to its activity. Integer rounding leaves some cycles over, and these go to the most active thread.

Top module: `arb_thread_place`

## Requirements
- R1: While reset is held and just after it is released, every core's free count equals SLOTS (4), grant_valid_o and no_slot_o are 0, rebal_o is 0, and every fetch share is 0.
- R2: When place_req_i or help_req_i is high at a clock edge, the core chosen is the one with the smallest selected activity among cores whose free count is non-zero. Its index appears on grant_core_o with grant_valid_o high in the cycle after that edge, and grant_valid_o is low after an edge with no request.
- R3: If several eligible cores share the minimum activity, the lowest core index is granted.
- R4: metric_sel_i = 0 makes the search compare ipc_act_i, and metric_sel_i = 1 makes it compare wipc_act_i. Core k's activity is bits [k*8 +: 8] of the chosen vector.
- R5: A grant lowers the chosen core's free count by one. release_i[k] raises core k's count by one, but not above SLOTS. A grant and a release for the same core in the same cycle leave its count unchanged. Core k's count is free_cnt_o[k*3 +: 3].
- R6: If a request arrives while every count is zero, no_slot_o is 1 in the next cycle, grant_valid_o stays 0, and no count changes.
- R7: grant_help_o is 1 together with grant_valid_o exactly when the granted request had help_req_i high.
- R8: rebal_o is a single-cycle pulse that repeats every REBAL_PERIOD cycles.
- R9: One cycle after thr_valid_i and thr_act_i are applied, each valid thread i with a non-zero activity sum S gets floor(B*A_i/S) fetch cycles, plus any leftover under R10. Thread i's share is fetch_share_o[i*7 +: 7] and its activity is thr_act_i[i*8 +: 8].
- R10: Cycles left over after rounding go to the valid thread with the highest activity, with the lowest index winning a tie, so the valid shares always add up to B.
- R11: If the valid threads all have zero activity, each gets floor(B/n), where n is the number of valid threads, and the remainder goes to the lowest-index valid thread.
- R12: An invalid thread's share is 0, and with no valid thread every share is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| metric_sel_i | input | 1 | 0 selects the IPC activity, 1 selects the weighted activity |
| ipc_act_i | input | N_CORES*ACT_W | Per-core IPC activity |
| wipc_act_i | input | N_CORES*ACT_W | Per-core weighted activity |
| place_req_i | input | 1 | Request to place a new thread |
| help_req_i | input | 1 | Request to move a checker thread that is falling behind |
| release_i | input | N_CORES | Per-core slot return strobe |
| grant_valid_o | output | 1 | A placement was granted |
| grant_core_o | output | CORE_W | Index of the granted core |
| grant_help_o | output | 1 | The grant served a help request |
| no_slot_o | output | 1 | A request found no free slot |
| free_cnt_o | output | N_CORES*CNT_W | Per-core free slot counts |
| rebal_o | output | 1 | Periodic rebalance pulse |
| thr_valid_i | input | SLOTS | Valid threads on the core whose fetch cycles are being split |
| thr_act_i | input | SLOTS*ACT_W | Per-thread activity |
| fetch_share_o | output | SLOTS*SHARE_W | Per-thread fetch cycles within the block |

## Verification
The assertions assume that release_i only returns slots that were granted earlier. They also assume that REBAL_PERIOD is at least 2, so that the pulse can be checked as a single cycle. The bench keeps its release strobes sparse and models saturation itself, so an over-release on a core that is already full is both legal and checked at the ports. Activity values are sometimes drawn from a narrow range, which forces ties in both the core search and the choice of which thread receives the leftover cycles. Thread patterns with zero activity, and patterns with no valid thread at all, are generated on purpose.

// File: rtl/arb_place_pkg.sv
package arb_place_pkg;
  typedef enum logic {
    METRIC_IPC  = 1'b0,
    METRIC_WIPC = 1'b1
  } metric_e;
endpackage

// File: rtl/arb_min_search.sv
module arb_min_search #(
  parameter int N_CORES = 16,
  parameter int ACT_W   = 8,
  parameter int CNT_W   = 3,
  localparam int CORE_W = $clog2(N_CORES)
) (
  input  logic [N_CORES*ACT_W-1:0] act_i,
  input  logic [N_CORES*CNT_W-1:0] free_cnt_i,
  output logic                     found_o,
  output logic [CORE_W-1:0]        idx_o
);
  logic [ACT_W-1:0] best;

  // strict compare keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < N_CORES; i++) begin
      if (free_cnt_i[i*CNT_W +: CNT_W] != '0 &&
          (!found_o || act_i[i*ACT_W +: ACT_W] < best)) begin
        found_o = 1'b1;
        best    = act_i[i*ACT_W +: ACT_W];
        idx_o   = CORE_W'(i);
      end
    end
  end
endmodule

// File: rtl/arb_slot_ctr.sv
module arb_slot_ctr #(
  parameter int SLOTS = 4,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             give_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= CNT_W'(SLOTS);
    end else if (take_i && !give_i) begin
      cnt_o <= cnt_o - 1'b1;
    end else if (give_i && !take_i && cnt_o != CNT_W'(SLOTS)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/arb_fetch_share.sv
module arb_fetch_share #(
  parameter int SLOTS = 4,
  parameter int ACT_W = 8,
  parameter int BLOCK = 64,
  localparam int SHARE_W = $clog2(BLOCK + 1),
  localparam int SUM_W   = ACT_W + $clog2(SLOTS + 1),
  localparam int PROD_W  = SUM_W + SHARE_W,
  localparam int NV_W    = $clog2(SLOTS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SLOTS-1:0]         valid_i,
  input  logic [SLOTS*ACT_W-1:0]   act_i,
  output logic [SLOTS*SHARE_W-1:0] share_o
);
  logic [SUM_W-1:0]         sum;
  logic [NV_W-1:0]          nvalid;
  logic [PROD_W-1:0]        raw   [SLOTS];
  logic [PROD_W-1:0]        used;
  logic [PROD_W-1:0]        left;
  logic [$clog2(SLOTS)-1:0] top_idx;
  logic                     top_found;
  logic [ACT_W-1:0]         top_act;
  logic [SHARE_W-1:0]       even;
  logic [SLOTS*SHARE_W-1:0] share_d;

  always_comb begin
    sum       = '0;
    nvalid    = '0;
    top_found = 1'b0;
    top_idx   = '0;
    top_act   = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (valid_i[i]) begin
        sum    = sum + SUM_W'(act_i[i*ACT_W +: ACT_W]);
        nvalid = nvalid + 1'b1;
        if (!top_found || act_i[i*ACT_W +: ACT_W] > top_act) begin
          top_found = 1'b1;
          top_act   = act_i[i*ACT_W +: ACT_W];
          top_idx   = ($clog2(SLOTS))'(i);
        end
      end
    end
    even = (nvalid == '0) ? '0 : SHARE_W'(SHARE_W'(BLOCK) / SHARE_W'(nvalid));
    used = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!valid_i[i])
        raw[i] = '0;
      else if (sum == '0)
        raw[i] = PROD_W'(even);
      else
        raw[i] = (PROD_W'(BLOCK) * PROD_W'(act_i[i*ACT_W +: ACT_W])) / PROD_W'(sum);
      used = used + raw[i];
    end
    left = top_found ? PROD_W'(BLOCK) - used : '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (top_found && top_idx == ($clog2(SLOTS))'(i))
        share_d[i*SHARE_W +: SHARE_W] = SHARE_W'(raw[i] + left);
      else
        share_d[i*SHARE_W +: SHARE_W] = SHARE_W'(raw[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) share_o <= '0;
    else         share_o <= share_d;
  end
endmodule

// File: rtl/arb_thread_place.sv
module arb_thread_place
  import arb_place_pkg::*;
#(
  parameter int N_CORES      = 16,
  parameter int SLOTS        = 4,
  parameter int ACT_W        = 8,
  parameter int BLOCK        = 64,
  parameter int REBAL_PERIOD = 1000,
  localparam int CORE_W  = $clog2(N_CORES),
  localparam int CNT_W   = $clog2(SLOTS + 1),
  localparam int SHARE_W = $clog2(BLOCK + 1),
  localparam int RB_W    = $clog2(REBAL_PERIOD)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     metric_sel_i,
  input  logic [N_CORES*ACT_W-1:0] ipc_act_i,
  input  logic [N_CORES*ACT_W-1:0] wipc_act_i,
  input  logic                     place_req_i,
  input  logic                     help_req_i,
  input  logic [N_CORES-1:0]       release_i,
  output logic                     grant_valid_o,
  output logic [CORE_W-1:0]        grant_core_o,
  output logic                     grant_help_o,
  output logic                     no_slot_o,
  output logic [N_CORES*CNT_W-1:0] free_cnt_o,
  output logic                     rebal_o,
  input  logic [SLOTS-1:0]         thr_valid_i,
  input  logic [SLOTS*ACT_W-1:0]   thr_act_i,
  output logic [SLOTS*SHARE_W-1:0] fetch_share_o
);
  metric_e                  metric;
  logic [N_CORES*ACT_W-1:0] act_sel;
  logic                     req;
  logic                     found;
  logic [CORE_W-1:0]        idx;
  logic                     take;
  logic [N_CORES-1:0]       take_vec;
  logic [RB_W-1:0]          rb_cnt;

  assign metric  = metric_e'(metric_sel_i);
  assign act_sel = (metric == METRIC_WIPC) ? wipc_act_i : ipc_act_i;
  assign req     = place_req_i | help_req_i;
  assign take    = req & found;

  arb_min_search #(.N_CORES(N_CORES), .ACT_W(ACT_W), .CNT_W(CNT_W)) u_search (
    .act_i     (act_sel),
    .free_cnt_i(free_cnt_o),
    .found_o   (found),
    .idx_o     (idx)
  );

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    assign take_vec[g] = take && (idx == CORE_W'(g));
    arb_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .take_i(take_vec[g]),
      .give_i(release_i[g]),
      .cnt_o (free_cnt_o[g*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_core_o  <= '0;
      grant_help_o  <= 1'b0;
      no_slot_o     <= 1'b0;
    end else begin
      grant_valid_o <= take;
      grant_help_o  <= take & help_req_i;
      no_slot_o     <= req & ~found;
      if (take) grant_core_o <= idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 rb_cnt <= '0;
    else if (rb_cnt == RB_W'(REBAL_PERIOD - 1))  rb_cnt <= '0;
    else                                         rb_cnt <= rb_cnt + 1'b1;
  end
  assign rebal_o = (rb_cnt == RB_W'(REBAL_PERIOD - 1));

  arb_fetch_share #(.SLOTS(SLOTS), .ACT_W(ACT_W), .BLOCK(BLOCK)) u_share (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(thr_valid_i),
    .act_i  (thr_act_i),
    .share_o(fetch_share_o)
  );
endmodule

// File: rtl/arb_thread_place_chk.sv
module arb_thread_place_chk #(
  parameter int N_CORES      = 16,
  parameter int SLOTS        = 4,
  parameter int ACT_W        = 8,
  parameter int BLOCK        = 64,
  parameter int REBAL_PERIOD = 1000,
  localparam int CORE_W  = $clog2(N_CORES),
  localparam int CNT_W   = $clog2(SLOTS + 1),
  localparam int SHARE_W = $clog2(BLOCK + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     grant_valid_o,
  input logic [CORE_W-1:0]        grant_core_o,
  input logic                     grant_help_o,
  input logic                     no_slot_o,
  input logic [N_CORES*CNT_W-1:0] free_cnt_o,
  input logic                     rebal_o,
  input logic [SLOTS-1:0]         thr_valid_i,
  input logic [SLOTS*SHARE_W-1:0] fetch_share_o
);
  logic [N_CORES*CNT_W-1:0] free_q;
  logic                     any_valid_q;
  logic [SHARE_W+SLOTS-1:0] share_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q      <= '0;
      any_valid_q <= 1'b0;
    end else begin
      free_q      <= free_cnt_o;
      any_valid_q <= |thr_valid_i;
    end
  end

  always_comb begin
    share_sum = '0;
    for (int i = 0; i < SLOTS; i++)
      share_sum = share_sum + (SHARE_W+SLOTS)'(fetch_share_o[i*SHARE_W +: SHARE_W]);
  end

  // R6
  grant_or_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_valid_o && no_slot_o));

  // R2
  grant_had_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> free_q[grant_core_o*CNT_W +: CNT_W] != '0);

  // R6
  no_slot_all_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_slot_o |-> free_q == '0);

  // R7
  help_needs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_help_o |-> grant_valid_o);

  // R8
  rebal_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rebal_o |=> !rebal_o);

  // R10
  share_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_valid_q |-> share_sum == (SHARE_W+SLOTS)'(BLOCK));

  for (genvar g = 0; g < N_CORES; g++) begin : g_bound
    // R5
    free_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      free_cnt_o[g*CNT_W +: CNT_W] <= CNT_W'(SLOTS));
  end
endmodule

bind arb_thread_place arb_thread_place_chk #(
  .N_CORES(N_CORES), .SLOTS(SLOTS), .ACT_W(ACT_W), .BLOCK(BLOCK),
  .REBAL_PERIOD(REBAL_PERIOD)
) u_chk (.*);

// File: tb/arb_thread_place_test.sv
module arb_thread_place_test;
  localparam int NC = 16, SL = 4, AW = 8, BL = 64, RP = 16;
  localparam int CW = 3, SW = 7;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             metric_sel = 0;
  logic [NC*AW-1:0] ipc_act = '0, wipc_act = '0;
  logic             place_req = 0, help_req = 0;
  logic [NC-1:0]    rel = '0;
  logic             grant_valid, grant_help, no_slot, rebal;
  logic [3:0]       grant_core;
  logic [NC*CW-1:0] free_cnt;
  logic [SL-1:0]    thr_valid = '0;
  logic [SL*AW-1:0] thr_act = '0;
  logic [SL*SW-1:0] share;

  int checks = 0, errors = 0;
  int fm[NC];
  int ia[NC], wa[NC];
  logic [31:0] seed = 32'h1ace_b00c;

  always #5 clk = ~clk;

  arb_thread_place #(.N_CORES(NC), .SLOTS(SL), .ACT_W(AW), .BLOCK(BL),
                     .REBAL_PERIOD(RP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .metric_sel_i(metric_sel),
    .ipc_act_i(ipc_act), .wipc_act_i(wipc_act),
    .place_req_i(place_req), .help_req_i(help_req), .release_i(rel),
    .grant_valid_o(grant_valid), .grant_core_o(grant_core),
    .grant_help_o(grant_help), .no_slot_o(no_slot), .free_cnt_o(free_cnt),
    .rebal_o(rebal), .thr_valid_i(thr_valid), .thr_act_i(thr_act),
    .fetch_share_o(share)
  );

  function automatic int rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'(seed & 32'h7fff_ffff);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic load_acts();
    for (int i = 0; i < NC; i++) begin
      ipc_act[i*AW +: AW]  = AW'(ia[i]);
      wipc_act[i*AW +: AW] = AW'(wa[i]);
    end
  endtask

  task automatic check_free(string req);
    for (int i = 0; i < NC; i++)
      check(req, int'(free_cnt[i*CW +: CW]), fm[i]);
  endtask

  // one request cycle against the reference model
  task automatic place_step(string req, bit help);
    int best = -1;
    int a;
    for (int i = 0; i < NC; i++) begin
      a = metric_sel ? wa[i] : ia[i];
      if (fm[i] > 0 && (best < 0 || a < (metric_sel ? wa[best] : ia[best]))) best = i;
    end
    place_req = !help;
    help_req  = help;
    tick();
    place_req = 0;
    help_req  = 0;
    if (best >= 0) fm[best]--;
    for (int i = 0; i < NC; i++) begin
      if (rel[i]) fm[i] = (fm[i] + 1 > SL) ? SL : fm[i] + 1;
    end
    rel = '0;
    check({req, " grant_valid"}, int'(grant_valid), best >= 0 ? 1 : 0);
    check({req, " no_slot"}, int'(no_slot), best < 0 ? 1 : 0);
    if (best >= 0) check({req, " core"}, int'(grant_core), best);
    check({req, " R7 help"}, int'(grant_help), (best >= 0 && help) ? 1 : 0);
    check_free({req, " R5 free"});
  endtask

  task automatic share_step(string req, logic [SL-1:0] v, int a0, int a1, int a2, int a3);
    int a[SL];
    int e[SL];
    int sum = 0, n = 0, used = 0, top = -1;
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    for (int i = 0; i < SL; i++) begin
      thr_act[i*AW +: AW] = AW'(a[i]);
      if (v[i]) begin
        sum += a[i];
        n++;
        if (top < 0 || a[i] > a[top]) top = i;
      end
    end
    thr_valid = v;
    for (int i = 0; i < SL; i++) begin
      if (!v[i])         e[i] = 0;
      else if (sum == 0) e[i] = BL / n;
      else               e[i] = (BL * a[i]) / sum;
      used += e[i];
    end
    if (top >= 0) e[top] += BL - used;
    tick();
    for (int i = 0; i < SL; i++)
      check(req, int'(share[i*SW +: SW]), e[i]);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin fm[i] = SL; ia[i] = 0; wa[i] = 0; end
    #23;
    // R1 reset state
    check_free("R1 free");
    check("R1 grant_valid", int'(grant_valid), 0);
    check("R1 no_slot", int'(no_slot), 0);
    check("R1 rebal", int'(rebal), 0);
    check("R1 share", int'(share), 0);
    @(negedge clk);
    rst_n = 1;
    tick();
    check("R2 idle no grant", int'(grant_valid), 0);

    // R3 all equal -> core 0
    for (int i = 0; i < NC; i++) begin ia[i] = 7; wa[i] = 7; end
    load_acts();
    place_step("R3 tie", 0);
    check("R3 tie core0", int'(grant_core), 0);

    // R4 metric selection
    for (int i = 0; i < NC; i++) begin ia[i] = 100; wa[i] = 100; end
    ia[5] = 3; wa[9] = 3;
    load_acts();
    metric_sel = 0;
    place_step("R4 ipc", 0);
    check("R4 ipc core5", int'(grant_core), 5);
    metric_sel = 1;
    place_step("R4 wipc", 1);
    check("R4 wipc core9", int'(grant_core), 9);

    // R5 release saturation on a full core, and grant+release same core
    rel[3] = 1;
    place_step("R5 sat", 1);
    for (int i = 0; i < NC; i++) begin ia[i] = 50; wa[i] = 50; end
    ia[9] = 1; wa[9] = 1;
    load_acts();
    rel[9] = 1;
    place_step("R5 same core", 0);

    // R2 R3 R6 sweep until exhaustion and beyond
    for (int it = 0; it < 160; it++) begin
      int r = rnd();
      metric_sel = r[0];
      for (int i = 0; i < NC; i++) begin
        ia[i] = (it % 2 == 0) ? rnd() % 4 : rnd() % 256;
        wa[i] = (it % 2 == 0) ? rnd() % 4 : rnd() % 256;
      end
      load_acts();
      if (rnd() % 8 == 0) rel[rnd() % NC] = 1;
      place_step((it > 100) ? "R6 sweep" : "R2 sweep", r[1]);
    end
    // all full now: one more request with no release must report no slot
    place_step("R6 empty", 0);
    check("R6 no_slot set", int'(no_slot), 1);

    // refill
    for (int k = 0; k < SL; k++) begin
      rel = '1;
      tick();
      for (int i = 0; i < NC; i++) fm[i] = (fm[i] + 1 > SL) ? SL : fm[i] + 1;
    end
    rel = '0;
    check_free("R5 refill");

    // fetch shares
    share_step("R12 none valid", 4'b0000, 9, 9, 9, 9);
    share_step("R11 zero split", 4'b0111, 0, 0, 0, 0);
    share_step("R11 zero one", 4'b1000, 0, 0, 0, 0);
    share_step("R10 tie leftover", 4'b1111, 5, 5, 5, 5);
    share_step("R9 ratio", 4'b1111, 10, 20, 30, 40);
    share_step("R12 invalid ignored", 4'b0101, 200, 255, 3, 255);
    for (int it = 0; it < 400; it++) begin
      int v = rnd() % 16;
      int m = (it % 3 == 0) ? 3 : 256;
      share_step("R9 R10 sweep", SL'(v), rnd() % m, rnd() % m, rnd() % m, rnd() % m);
    end

    // R8 rebalance period
    while (rebal !== 1'b1) tick();
    for (int rep = 0; rep < 3; rep++) begin
      int n = 0;
      tick();
      n = 1;
      while (rebal !== 1'b1 && n < 100) begin tick(); n++; end
      check("R8 period", n, RP);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule